// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit with Condition Flags

This block moves an 8-bit or 16-bit operand by a number of bit positions. It supports logical left and right shifts, an arithmetic right shift, plain rotates, and rotates that pass through the carry flag. It returns the moved value together with new carry, overflow, zero and sign flags.

The distance is either the value of an 8-bit count input or the constant 1. The unit moves the operand one bit position per clock cycle. A caller pulses `start` with the operand, the operation code and the current flags. It then waits for the one-cycle `done` pulse and takes the result and flags in that same cycle.

Operand fetch and write-back of the result are outside this block.

Top module: `shrot_unit`

## Requirements
- R1: When `useCountReg` is 1, the distance is the 8-bit value on `countReg`. When it is 0, the distance is 1 and `countReg` is ignored.
- R2: `start` is taken only while `busy` is low. All inputs are sampled on that edge, and `start` is ignored while `busy` is high. `done` is a one-cycle pulse that is high exactly N cycles after the start edge, where N is the distance (N = 0 gives `done` in the first cycle after the start edge). `busy` is high from the start edge through the `done` cycle, and both are low after reset.
- R3: Operation codes on `opSel` are 0 = shift left with zero fill, 1 = logical shift right with zero fill, and 2 = arithmetic shift right, which copies the sign bit into the vacated top position.
- R4: Code 3 rotates left and code 4 rotates right. The bit leaving one end enters the other end of the operand.
- R5: Code 5 rotates left through carry and code 6 rotates right through carry. In these, carry and operand form a ring of 9 positions (byte) or 17 positions (word), with carry placed above the operand's top bit.
- R6: After a nonzero distance, `carryOut` holds the last bit moved out of the operand: the top bit for left moves and bit 0 for right moves.
- R7: After a nonzero distance, `ovfOut` is (new top bit XOR new carry) for left moves (codes 0, 3, 5, 7). For right moves it is the XOR of the two highest bits of the result.
- R8: Shifts (codes 0, 1, 2, 7) set `zeroOut` when the result is zero and set `signOut` to the top bit of the result.
- R9: Rotates (codes 3 to 6) leave `zeroOut` and `signOut` equal to `zeroIn` and `signIn`.
- R10: A distance of 0 returns the operand unchanged and all four flags equal to their inputs.
- R11: With `wordMode` = 0, only `operand[7:0]` takes part, bit 7 is the top bit, and `result[15:8]` is 0. With `wordMode` = 1, all 16 bits take part and bit 15 is the top bit.
- R12: Code 7 behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| opSel | input | 3 | Operation code |
| wordMode | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| useCountReg | input | 1 | 1 = distance from countReg, 0 = distance 1 |
| countReg | input | 8 | Distance when selected |
| operand | input | 16 | Value to be moved |
| carryIn | input | 1 | Current carry flag |
| zeroIn | input | 1 | Current zero flag |
| signIn | input | 1 | Current sign flag |
| ovfIn | input | 1 | Current overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result and flags valid this cycle |
| result | output | 16 | Moved value |
| carryOut | output | 1 | New carry flag |
| ovfOut | output | 1 | New overflow flag |
| zeroOut | output | 1 | New zero flag |
| signOut | output | 1 | New sign flag |

## Verification
The bench goes after several boundary cases:
- Distances equal to, one above and well beyond the operand width. A unit that stopped early or wrapped its shift count would return stale bits or a wrong carry there.
- Rotates through carry at distances equal to 8, 9, 16 and 17. A ring one position too short would be detected, because only the 9- and 17-position rings return to the start value after ring-length steps.
- The byte mode, checked with a non-zero upper operand byte. Leakage of that byte would show in the result and in the sign and zero flags.
- A zero distance, together with overflow on right moves. A wrong overflow tap or a clobbered flag on a zero distance would miscompare.
- The `done` latency for every distance, and a `start` raised mid-operation. An off-by-one counter or a restart while busy would change the measured cycle count or the result.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL     = 3'd0,
    OP_SHR     = 3'd1,
    OP_SAR     = 3'd2,
    OP_ROL     = 3'd3,
    OP_ROR     = 3'd4,
    OP_RCL     = 3'd5,
    OP_RCR     = 3'd6,
    OP_SHL_ALT = 3'd7
  } shiftOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture operand, op and flags
    logic step;  // move one bit position
  } stepStrobe_t;

endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             useCountReg,
  input  logic [CNT_W-1:0] countReg,
  output stepStrobe_t      strobe,
  output logic             busy,
  output logic             done
);

  logic             busyQ;
  logic [CNT_W-1:0] remainQ;
  logic             accept;
  logic [CNT_W-1:0] effCount;

  assign accept   = start && !busyQ;
  assign effCount = useCountReg ? countReg : CNT_W'(1);

  assign strobe.load = accept;
  assign strobe.step = busyQ && (remainQ != '0);
  assign busy        = busyQ;
  assign done        = busyQ && (remainQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      remainQ <= '0;
    end else if (accept) begin
      busyQ   <= 1'b1;
      remainQ <= effCount;
    end else if (busyQ) begin
      if (remainQ != '0) remainQ <= remainQ - 1'b1;
      else               busyQ   <= 1'b0;
    end
  end

endmodule

// File: rtl/shrot_dp.sv
module shrot_dp
  import shrot_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobe_t       strobe,
  input  logic [2:0]        opSel,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              zeroIn,
  input  logic              signIn,
  input  logic              ovfIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              ovfOut,
  output logic              zeroOut,
  output logic              signOut
);

  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] FULL_MASK = '1;
  localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  shiftOp_e          opQ;
  logic              wordQ;
  logic [DATA_W-1:0] valQ;
  logic              carryQ, ovfQ, zeroQ, signQ;

  logic [DATA_W-1:0] curMask, loadMask, nextVal;
  logic [IDX_W-1:0]  topIdx, nextIdx;
  logic              moveLeft, isShift, fill, curTop, newCarry, newTop, newNext, newOvf;

  assign curMask  = wordQ ? FULL_MASK : HALF_MASK;
  assign loadMask = wordMode ? FULL_MASK : HALF_MASK;
  assign topIdx   = wordQ ? IDX_W'(DATA_W-1) : IDX_W'(HALF_W-1);
  assign nextIdx  = topIdx - 1'b1;
  assign curTop   = valQ[topIdx];

  always_comb begin
    moveLeft = 1'b0;
    isShift  = 1'b0;
    fill     = 1'b0;
    unique case (opQ)
      OP_SHL, OP_SHL_ALT: begin moveLeft = 1'b1; isShift = 1'b1; fill = 1'b0;    end
      OP_SHR:             begin moveLeft = 1'b0; isShift = 1'b1; fill = 1'b0;    end
      OP_SAR:             begin moveLeft = 1'b0; isShift = 1'b1; fill = curTop;  end
      OP_ROL:             begin moveLeft = 1'b1; fill = curTop;                  end
      OP_ROR:             begin moveLeft = 1'b0; fill = valQ[0];                 end
      OP_RCL:             begin moveLeft = 1'b1; fill = carryQ;                  end
      OP_RCR:             begin moveLeft = 1'b0; fill = carryQ;                  end
      default:            begin moveLeft = 1'b1; isShift = 1'b1;                 end
    endcase
  end

  always_comb begin
    if (moveLeft) begin
      nextVal  = ((valQ << 1) | {{(DATA_W-1){1'b0}}, fill}) & curMask;
      newCarry = curTop;
    end else begin
      nextVal          = valQ >> 1;
      nextVal[topIdx]  = fill;
      newCarry         = valQ[0];
    end
    newTop  = nextVal[topIdx];
    newNext = nextVal[nextIdx];
    newOvf  = moveLeft ? (newTop ^ newCarry) : (newTop ^ newNext);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ    <= OP_SHL;
      wordQ  <= 1'b0;
      valQ   <= '0;
      carryQ <= 1'b0;
      ovfQ   <= 1'b0;
      zeroQ  <= 1'b0;
      signQ  <= 1'b0;
    end else if (strobe.load) begin
      opQ    <= shiftOp_e'(opSel);
      wordQ  <= wordMode;
      valQ   <= operand & loadMask;
      carryQ <= carryIn;
      ovfQ   <= ovfIn;
      zeroQ  <= zeroIn;
      signQ  <= signIn;
    end else if (strobe.step) begin
      valQ   <= nextVal;
      carryQ <= newCarry;
      ovfQ   <= newOvf;
      if (isShift) begin
        zeroQ <= (nextVal == '0);
        signQ <= newTop;
      end
    end
  end

  assign result   = valQ;
  assign carryOut = carryQ;
  assign ovfOut   = ovfQ;
  assign zeroOut  = zeroQ;
  assign signOut  = signQ;

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic              wordMode,
  input  logic              useCountReg,
  input  logic [CNT_W-1:0]  countReg,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              zeroIn,
  input  logic              signIn,
  input  logic              ovfIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              ovfOut,
  output logic              zeroOut,
  output logic              signOut
);

  stepStrobe_t strobe;

  shrot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .useCountReg (useCountReg),
    .countReg    (countReg),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done)
  );

  shrot_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opSel    (opSel),
    .wordMode (wordMode),
    .operand  (operand),
    .carryIn  (carryIn),
    .zeroIn   (zeroIn),
    .signIn   (signIn),
    .ovfIn    (ovfIn),
    .result   (result),
    .carryOut (carryOut),
    .ovfOut   (ovfOut),
    .zeroOut  (zeroOut),
    .signOut  (signOut)
  );

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        opSel,
  input logic              wordMode,
  input logic              useCountReg,
  input logic [CNT_W-1:0]  countReg,
  input logic [DATA_W-1:0] operand,
  input logic              carryIn,
  input logic              zeroIn,
  input logic              signIn,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              zeroOut,
  input logic              signOut
);

  localparam int HALF_W = DATA_W / 2;

  logic             accept;
  logic [CNT_W-1:0] effCount;
  logic [DATA_W-1:0] maskedOp;
  logic [CNT_W-1:0] cntLat, elapsedQ;
  logic             rotLat, wordLat, zeroLat, signLat;

  assign accept   = start && !busy;
  assign effCount = useCountReg ? countReg : CNT_W'(1);
  assign maskedOp = wordMode ? operand : (operand & {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLat <= '0; elapsedQ <= '0; rotLat <= 1'b0; wordLat <= 1'b0;
      zeroLat <= 1'b0; signLat <= 1'b0;
    end else if (accept) begin
      cntLat   <= effCount;
      elapsedQ <= '0;
      rotLat   <= (opSel >= 3'd3) && (opSel <= 3'd6);
      wordLat  <= wordMode;
      zeroLat  <= zeroIn;
      signLat  <= signIn;
    end else if (busy && !done) begin
      elapsedQ <= elapsedQ + 1'b1;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rstN) (busy && !done) |=> busy);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN) done |-> (elapsedQ == cntLat));
  p_rot_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && rotLat) |-> (zeroOut == zeroLat && signOut == signLat));
  p_zero_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accept && effCount == '0) |=> (done && result == $past(maskedOp) && carryOut == $past(carryIn)));
  p_byte_upper_r11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !wordLat) |-> (result[DATA_W-1:HALF_W] == '0));

endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .wordMode(wordMode),
  .useCountReg(useCountReg), .countReg(countReg), .operand(operand),
  .carryIn(carryIn), .zeroIn(zeroIn), .signIn(signIn), .busy(busy), .done(done),
  .result(result), .carryOut(carryOut), .zeroOut(zeroOut), .signOut(signOut)
);

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic        wordMode = 1'b0;
  logic        useCountReg = 1'b0;
  logic [7:0]  countReg = '0;
  logic [15:0] operand = '0;
  logic        carryIn = 1'b0, zeroIn = 1'b0, signIn = 1'b0, ovfIn = 1'b0;
  logic        busy, done, carryOut, ovfOut, zeroOut, signOut;
  logic [15:0] result;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  shrot_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .wordMode(wordMode),
    .useCountReg(useCountReg), .countReg(countReg), .operand(operand),
    .carryIn(carryIn), .zeroIn(zeroIn), .signIn(signIn), .ovfIn(ovfIn),
    .busy(busy), .done(done), .result(result), .carryOut(carryOut),
    .ovfOut(ovfOut), .zeroOut(zeroOut), .signOut(signOut)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (op=%0d word=%0d cnt=%0d opnd=%0h)",
               tag, act, exp, opSel, wordMode, useCountReg ? countReg : 8'd1, operand);
    end
  endtask

  // Closed-form reference from the requirements
  function automatic void model(input int op, input bit wm, input int n, input longint aIn,
                                input bit cin, input bit zin, input bit sin, input bit oin,
                                output longint r, output bit c, output bit o, output bit z, output bit s);
    int W = wm ? 16 : 8;
    longint mask = (longint'(1) << W) - 1;
    longint a = aIn & mask;
    longint sx, ring, rmask;
    int k, R;
    bit left;
    if (n == 0) begin
      r = a; c = cin; o = oin; z = zin; s = sin;
      return;
    end
    R = W + 1;
    rmask = (longint'(1) << R) - 1;
    left = (op == 0 || op == 3 || op == 5 || op == 7);
    case (op)
      1: begin
        r = (n >= W) ? 0 : (a >> n);
        c = (n <= W) ? bit'((a >> (n - 1)) & 1) : 1'b0;
      end
      2: begin
        sx = ((a >> (W - 1)) & 1) != 0 ? a - (longint'(1) << W) : a;
        r = (sx >>> ((n > W) ? W : n)) & mask;
        c = bit'((sx >>> (((n - 1) > W) ? W : (n - 1))) & 1);
      end
      3: begin
        k = n % W;
        r = ((a << k) | (a >> (W - k))) & mask;
        c = bit'(r & 1);
      end
      4: begin
        k = n % W;
        r = ((a >> k) | (a << (W - k))) & mask;
        c = bit'((r >> (W - 1)) & 1);
      end
      5: begin
        k = n % R;
        ring = (longint'(cin) << W) | a;
        ring = ((ring << k) | (ring >> (R - k))) & rmask;
        r = ring & mask;
        c = bit'((ring >> W) & 1);
      end
      6: begin
        k = n % R;
        ring = (longint'(cin) << W) | a;
        ring = ((ring >> k) | (ring << (R - k))) & rmask;
        r = ring & mask;
        c = bit'((ring >> W) & 1);
      end
      default: begin
        r = (n >= W) ? 0 : ((a << n) & mask);
        c = (n <= W) ? bit'((a >> (W - n)) & 1) : 1'b0;
      end
    endcase
    if (left) o = bit'((r >> (W - 1)) & 1) ^ c;
    else      o = bit'(((r >> (W - 1)) ^ (r >> (W - 2))) & 1);
    if (op <= 2 || op == 7) begin
      z = (r == 0);
      s = bit'((r >> (W - 1)) & 1);
    end else begin
      z = zin; s = sin;
    end
  endfunction

  task automatic launch(input int op, input bit wm, input bit useReg, input int cnt,
                        input longint a, input bit cin, input bit zin, input bit sin, input bit oin);
    @(negedge clk);
    opSel = op[2:0]; wordMode = wm; useCountReg = useReg; countReg = cnt[7:0];
    operand = a[15:0]; carryIn = cin; zeroIn = zin; signIn = sin; ovfIn = oin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int cycles);
    cycles = 0;
    while (!done && cycles < 600) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic runOp(input int op, input bit wm, input bit useReg, input int cnt,
                       input longint a, input bit cin, input bit zin, input bit sin, input bit oin);
    longint er; bit ec, eo, ez, es;
    int n, cycles;
    string rtag;
    n = useReg ? cnt : 1;
    model(op, wm, n, a, cin, zin, sin, oin, er, ec, eo, ez, es);
    launch(op, wm, useReg, cnt, a, cin, zin, sin, oin);
    waitDone(cycles);
    check(cycles == n, useReg ? "R2 latency" : "R1 R2 constant-one latency", cycles, n);
    if (n == 0)                     rtag = "R10 result";
    else if (op == 7)               rtag = "R12 result";
    else if (op >= 5)               rtag = "R5 result";
    else if (op >= 3)               rtag = "R4 result";
    else                            rtag = "R3 result";
    if (!wm) rtag = {rtag, " R11"};
    check(longint'(result) == er, rtag, result, er);
    check(carryOut == ec, (n == 0) ? "R10 carry" : "R6 carry", carryOut, ec);
    check(ovfOut == eo, (n == 0) ? "R10 overflow" : "R7 overflow", ovfOut, eo);
    check(zeroOut == ez && signOut == es,
          (op >= 3 && op <= 6) ? "R9 zero/sign" : "R8 zero/sign",
          {zeroOut, signOut}, {ez, es});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int byteCnts[7] = '{0, 1, 2, 7, 8, 9, 15};
    int wordCnts[7] = '{0, 1, 4, 15, 16, 17, 33};
    longint a;
    longint er; bit ec, eo, ez, es;
    int cycles;

    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R2 reset idle", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R2 idle after reset", {busy, done}, 0);

    // Byte mode sweep, upper operand byte is junk (R11)
    for (int i = 0; i < 32; i++) begin
      a = (i == 0) ? 0 : (i == 1) ? 'h80 : (i == 2) ? 'hFF : ((i * 73 + 11) & 255);
      a = a | 'hA500;
      for (int op = 0; op < 8; op++) begin
        for (int p = 0; p < 2; p++) begin
          for (int ci = 0; ci < 7; ci++)
            runOp(op, 1'b0, 1'b1, byteCnts[ci], a, p[0], p[0], !p[0], p[0]);
          runOp(op, 1'b0, 1'b0, 200, a, p[0], !p[0], p[0], !p[0]);  // R1
        end
      end
    end

    // Word mode sweep
    for (int i = 0; i < 16; i++) begin
      a = (i == 0) ? 'h8000 : (i == 1) ? 0 : ((i * 40503 + 7) & 'hFFFF);
      for (int op = 0; op < 8; op++) begin
        for (int p = 0; p < 2; p++) begin
          for (int ci = 0; ci < 7; ci++)
            runOp(op, 1'b1, 1'b1, wordCnts[ci], a, p[0], !p[0], p[0], p[0]);
          runOp(op, 1'b1, 1'b0, 0, a, p[0], p[0], p[0], !p[0]);  // R1
        end
      end
    end

    // Largest distance
    runOp(6, 1'b1, 1'b1, 255, 'h1234, 1'b1, 1'b0, 1'b0, 1'b0);
    runOp(2, 1'b1, 1'b1, 255, 'h8001, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2: start raised while busy is ignored
    model(0, 1'b1, 5, 'h0003, 1'b0, 1'b0, 1'b0, 1'b0, er, ec, eo, ez, es);
    launch(0, 1'b1, 1'b1, 5, 'h0003, 1'b0, 1'b0, 1'b0, 1'b0);
    opSel = 3'd4; operand = 16'hF0F0; countReg = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(cycles);
    check(cycles == 4, "R2 busy restart ignored latency", cycles, 4);
    check(longint'(result) == er && carryOut == ec, "R2 busy restart ignored result", result, er);
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R2 idle after busy test", {busy, done}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule